// File: doc/BRIEF.md
# Streaming Image Accumulator (8-bit into 16-bit)

This block adds an 8-bit source image into a 16-bit accumulation image, one group of pixels per stream beat. A run starts with a one-cycle `start` pulse that sets the number of pixel groups and the base addresses of both images. For each group the block takes the 8-bit source pixels and the matching 16-bit destination pixels on one input beat. It widens every source pixel to 16 bits with a zero upper byte, adds it lane by lane to the destination pixel, and presents the sums as one output beat ready to be written back.

The source and destination pixels are different sizes, so the two current fetch addresses advance by different amounts per group: the source size in bytes for one, the destination size in bytes for the other. Each output beat carries the write-back address of its group and flags the final group. When the final beat has been taken, `done` rises and stays high until the next run starts. The memory system that fetches and stores the pixels lies outside the block.

Top module: `imgAccumTop`

## Requirements
- R1: During and right after reset, `outValid`, `inReady`, `busy` and `done` are all 0.
- R2: For each lane i (0..LANES-1), output bits [16i+15:16i] equal destination bits [16i+15:16i] plus source bits [8i+7:8i] with a zero upper byte.
- R3: The lane addition wraps modulo 2^16 with no saturation. For example, 0xFFFF + 0xFF gives 0x00FE.
- R4: An input beat accepted at a clock edge appears as an output beat with `outValid` high right after that edge.
- R5: Before group k is accepted, `srcAddr` equals srcBase + 16k and `dstAddr` equals dstBase + 32k. The output beat of group k carries `outAddr` = dstBase + 32k.
- R6: A run with group count N produces exactly N output beats. `outLast` is 1 on the Nth beat only.
- R7: `done` rises the cycle after the final beat is taken. It stays high until a new run with a nonzero count starts.
- R8: A start with a group count of 0 sets `done` the next cycle and produces no output beat.
- R9: While `outValid` is high and `outReady` is low, `inReady` is 0 and `outData`, `outLast` and `outAddr` hold their values.
- R10: A `start` pulse while `busy` is high has no effect on the count, the addresses or the data of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| groupCount | input | CNT_W | Number of pixel groups in the run |
| srcBase | input | ADDR_W | Byte address of the first source group |
| dstBase | input | ADDR_W | Byte address of the first destination group |
| busy | output | 1 | Run in progress, including draining the last beat |
| done | output | 1 | Last run finished |
| inValid | input | 1 | Input beat present |
| inReady | output | 1 | Input beat accepted at this edge if valid |
| inSrc | input | LANES*8 | Source pixels, lane i at bits [8i+7:8i] |
| inDst | input | LANES*16 | Destination pixels, lane i at bits [16i+15:16i] |
| srcAddr | output | ADDR_W | Source address of the group now wanted |
| dstAddr | output | ADDR_W | Destination address of the group now wanted |
| outValid | output | 1 | Output beat present |
| outReady | input | 1 | Consumer takes the output beat |
| outData | output | LANES*16 | Updated 16-bit pixels |
| outLast | output | 1 | Output beat is the final group |
| outAddr | output | ADDR_W | Write-back address of the output beat |

## Verification
The assertions check the following on every cycle:
- The stall rule: the output holds its values and input is refused under backpressure.
- The one-cycle latency from an accepted input beat to its output beat.
- The address stride after each accepted beat.
- The sum in lane 0.
- `done` following the final beat, and an immediate `done` on a zero count.

Only the bench's scenarios can show some things. These are the sum in every lane, including the wrap-around corner values, and that exactly N beats are produced with `outLast` only on the final one. They also include `done` persisting between runs, and that a start pulse in mid-run leaves the count and addresses unchanged.

// File: rtl/imgAccumPkg.sv
package imgAccumPkg;
  typedef struct packed {
    logic load;
    logic last;
  } accStrobe_t;
endpackage

// File: rtl/accCtrl.sv
module accCtrl
  import imgAccumPkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 32,
  parameter int SRC_STEP = 16,
  parameter int DST_STEP = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  groupCount,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic              inValid,
  input  logic              outReady,
  output logic              inReady,
  output logic              outValid,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output accStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] SRC_INC = ADDR_W'(SRC_STEP);
  localparam logic [ADDR_W-1:0] DST_INC = ADDR_W'(DST_STEP);

  logic [CNT_W-1:0] remaining;
  logic feeding;
  logic outValidR;
  logic finalOut;
  logic doneR;
  logic fire;
  logic finalFire;
  logic launch;

  assign inReady   = feeding && (!outValidR || outReady);
  assign fire      = inValid && inReady;
  assign finalFire = fire && (remaining == CNT_W'(1));
  assign busy      = feeding || outValidR;
  assign launch    = start && !busy;

  assign strobe.load = fire;
  assign strobe.last = finalFire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= '0;
      feeding   <= 1'b0;
      srcAddr   <= '0;
      dstAddr   <= '0;
      outValidR <= 1'b0;
      finalOut  <= 1'b0;
      doneR     <= 1'b0;
    end else begin
      if (launch) begin
        remaining <= groupCount;
        srcAddr   <= srcBase;
        dstAddr   <= dstBase;
        feeding   <= (groupCount != '0);
        doneR     <= (groupCount == '0);
      end else if (fire) begin
        remaining <= remaining - CNT_W'(1);
        srcAddr   <= srcAddr + SRC_INC;
        dstAddr   <= dstAddr + DST_INC;
        if (finalFire) feeding <= 1'b0;
      end

      if (fire) begin
        outValidR <= 1'b1;
        finalOut  <= finalFire;
      end else if (outReady) begin
        outValidR <= 1'b0;
      end

      if (outValidR && outReady && finalOut) doneR <= 1'b1;
    end
  end

  assign outValid = outValidR;
  assign done     = doneR;
endmodule

// File: rtl/accPath.sv
module accPath
  import imgAccumPkg::*;
#(
  parameter int LANES  = 16,
  parameter int SRC_W  = 8,
  parameter int DST_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  accStrobe_t             strobe,
  input  logic [LANES*SRC_W-1:0] inSrc,
  input  logic [LANES*DST_W-1:0] inDst,
  input  logic [ADDR_W-1:0]      dstAddr,
  output logic [LANES*DST_W-1:0] outData,
  output logic                   outLast,
  output logic [ADDR_W-1:0]      outAddr
);
  localparam int PAD_W = DST_W - SRC_W;

  logic [LANES*DST_W-1:0] laneSum;

  for (genvar i = 0; i < LANES; i++) begin : gLane
    logic [DST_W-1:0] widened;
    assign widened = {{PAD_W{1'b0}}, inSrc[i*SRC_W +: SRC_W]};
    assign laneSum[i*DST_W +: DST_W] = inDst[i*DST_W +: DST_W] + widened;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData <= '0;
      outLast <= 1'b0;
      outAddr <= '0;
    end else if (strobe.load) begin
      outData <= laneSum;
      outLast <= strobe.last;
      outAddr <= dstAddr;
    end
  end
endmodule

// File: rtl/imgAccumTop.sv
module imgAccumTop
  import imgAccumPkg::*;
#(
  parameter int LANES  = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [CNT_W-1:0]    groupCount,
  input  logic [ADDR_W-1:0]   srcBase,
  input  logic [ADDR_W-1:0]   dstBase,
  output logic                busy,
  output logic                done,
  input  logic                inValid,
  output logic                inReady,
  input  logic [LANES*8-1:0]  inSrc,
  input  logic [LANES*16-1:0] inDst,
  output logic [ADDR_W-1:0]   srcAddr,
  output logic [ADDR_W-1:0]   dstAddr,
  output logic                outValid,
  input  logic                outReady,
  output logic [LANES*16-1:0] outData,
  output logic                outLast,
  output logic [ADDR_W-1:0]   outAddr
);
  localparam int SRC_W    = 8;
  localparam int DST_W    = 16;
  localparam int SRC_STEP = LANES * SRC_W / 8;
  localparam int DST_STEP = LANES * DST_W / 8;

  accStrobe_t strobe;

  accCtrl #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .SRC_STEP(SRC_STEP), .DST_STEP(DST_STEP)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .groupCount(groupCount),
    .srcBase(srcBase), .dstBase(dstBase), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .busy(busy), .done(done),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .strobe(strobe)
  );

  accPath #(
    .LANES(LANES), .SRC_W(SRC_W), .DST_W(DST_W), .ADDR_W(ADDR_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inSrc(inSrc), .inDst(inDst),
    .dstAddr(dstAddr), .outData(outData), .outLast(outLast), .outAddr(outAddr)
  );
endmodule

// File: rtl/imgAccumChecker.sv
module imgAccumChecker #(
  parameter int LANES  = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic [CNT_W-1:0]    groupCount,
  input logic                busy,
  input logic                done,
  input logic                inValid,
  input logic                inReady,
  input logic [LANES*8-1:0]  inSrc,
  input logic [LANES*16-1:0] inDst,
  input logic [ADDR_W-1:0]   srcAddr,
  input logic [ADDR_W-1:0]   dstAddr,
  input logic                outValid,
  input logic                outReady,
  input logic [LANES*16-1:0] outData,
  input logic                outLast,
  input logic [ADDR_W-1:0]   outAddr
);
  localparam logic [ADDR_W-1:0] SRC_INC = ADDR_W'(LANES);
  localparam logic [ADDR_W-1:0] DST_INC = ADDR_W'(LANES * 2);

  logic take;
  assign take = inValid && inReady;

  a_r4_out_follows: assert property (@(posedge clk) disable iff (!rstN)
    take |=> outValid);

  a_r9_hold_beat: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast) && $stable(outAddr)));

  a_r9_block_input: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  a_r5_src_stride: assert property (@(posedge clk) disable iff (!rstN)
    take |=> (srcAddr == $past(srcAddr) + SRC_INC));

  a_r5_dst_stride: assert property (@(posedge clk) disable iff (!rstN)
    take |=> (dstAddr == $past(dstAddr) + DST_INC && outAddr == $past(dstAddr)));

  a_r2_lane_zero: assert property (@(posedge clk) disable iff (!rstN)
    take |=> (outData[15:0] == $past(inDst[15:0]) + {8'h00, $past(inSrc[7:0])}));

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> (done && !busy));

  a_r8_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && groupCount == '0) |=> (done && !outValid && !inReady));

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy && !take) |=> $stable(srcAddr) && $stable(dstAddr));

  a_r1_idle_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!inReady && !outValid));
endmodule

bind imgAccumTop imgAccumChecker #(.LANES(LANES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .groupCount(groupCount), .busy(busy),
  .done(done), .inValid(inValid), .inReady(inReady), .inSrc(inSrc), .inDst(inDst),
  .srcAddr(srcAddr), .dstAddr(dstAddr), .outValid(outValid), .outReady(outReady),
  .outData(outData), .outLast(outLast), .outAddr(outAddr)
);

// File: tb/tb_imgAccumTop.sv
`timescale 1ns/1ps
module tb_imgAccumTop;
  localparam int LANES = 16;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] groupCount = '0;
  logic [ADDR_W-1:0] srcBase = '0;
  logic [ADDR_W-1:0] dstBase = '0;
  logic busy, done, inReady, outValid, outLast;
  logic inValid = 1'b0;
  logic outReady = 1'b0;
  logic [LANES*8-1:0] inSrc = '0;
  logic [LANES*16-1:0] inDst = '0;
  logic [ADDR_W-1:0] srcAddr, dstAddr, outAddr;
  logic [LANES*16-1:0] outData;

  imgAccumTop #(.LANES(LANES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .groupCount(groupCount),
    .srcBase(srcBase), .dstBase(dstBase), .busy(busy), .done(done),
    .inValid(inValid), .inReady(inReady), .inSrc(inSrc), .inDst(inDst),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outLast(outLast), .outAddr(outAddr)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [LANES*16-1:0] data;
    logic last;
    logic [ADDR_W-1:0] addr;
    string tag;
  } expBeat_t;

  expBeat_t expQ[$];
  int checks = 0;
  int fails = 0;
  int beatsSeen = 0;
  int stallMode = 0;
  bit expectDone = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: drives outReady, pops and compares the scoreboard
  initial begin
    logic [LANES*16-1:0] heldData;
    bit wasStall;
    wasStall = 1'b0;
    heldData = '0;
    forever begin
      @(negedge clk);
      outReady = (stallMode == 0) ? 1'b1 : (($urandom % 3) != 0);
      #1;
      if (expectDone) begin
        chk(done === 1'b1, "R7 done after last beat", {255'b0, done}, 256'd1);
        expectDone = 1'b0;
      end
      if (wasStall && outValid)
        chk(outData === heldData, "R9 data held under stall", outData, heldData);
      wasStall = 1'b0;
      if (outValid && !outReady) begin
        chk(inReady === 1'b0, "R9 input blocked under stall", {255'b0, inReady}, 256'd0);
        wasStall = 1'b1;
        heldData = outData;
      end
      if (outValid && outReady) begin
        beatsSeen++;
        if (expQ.size() == 0) begin
          chk(1'b0, "R6 unexpected output beat", outData, 256'd0);
        end else begin
          expBeat_t e;
          e = expQ.pop_front();
          chk(outData === e.data, e.tag, outData, e.data);
          chk(outLast === e.last, "R6 last flag", {255'b0, outLast}, {255'b0, e.last});
          chk(outAddr === e.addr, "R5 write-back address", {224'b0, outAddr}, {224'b0, e.addr});
          if (e.last) expectDone = 1'b1;
        end
      end
    end
  end

  task automatic runJob(input int count, input logic [ADDR_W-1:0] sb, input logic [ADDR_W-1:0] db,
                        input int kind, input bit poke);
    int startBeats;
    startBeats = beatsSeen;
    @(negedge clk);
    start = 1'b1; groupCount = CNT_W'(count); srcBase = sb; dstBase = db;
    @(negedge clk);
    start = 1'b0;
    if (count == 0) begin
      #2;
      chk(done === 1'b1, "R8 zero count done", {255'b0, done}, 256'd1);
      repeat (4) begin
        @(negedge clk); #2;
        chk(outValid === 1'b0, "R8 no beat on zero count", {255'b0, outValid}, 256'd0);
      end
      return;
    end
    for (int k = 0; k < count; k++) begin
      logic [LANES*8-1:0] s;
      logic [LANES*16-1:0] d;
      expBeat_t e;
      for (int i = 0; i < LANES; i++) begin
        if (kind == 1) begin
          s[i*8 +: 8] = (i % 2 == 0) ? 8'hFF : 8'h80;
          d[i*16 +: 16] = (i % 2 == 0) ? 16'hFFFF : 16'hFF80;
        end else begin
          s[i*8 +: 8] = 8'($urandom);
          d[i*16 +: 16] = 16'($urandom);
        end
      end
      for (int i = 0; i < LANES; i++)
        e.data[i*16 +: 16] = d[i*16 +: 16] + {8'h00, s[i*8 +: 8]};
      e.last = (k == count - 1);
      e.addr = db + ADDR_W'(32 * k);
      e.tag = (kind == 1) ? "R3 wrapping lane sum" : "R2 lane sum";
      inValid = 1'b1; inSrc = s; inDst = d;
      if (poke && k == 1) begin
        start = 1'b1; groupCount = 9; srcBase = 32'hDEAD_0000; dstBase = 32'hBEEF_0000;
      end
      forever begin
        #2;
        if (inReady) begin
          chk(srcAddr === sb + ADDR_W'(16 * k), poke ? "R10 source address kept" : "R5 source address",
              {224'b0, srcAddr}, {224'b0, sb + ADDR_W'(16 * k)});
          chk(dstAddr === db + ADDR_W'(32 * k), "R5 destination address",
              {224'b0, dstAddr}, {224'b0, db + ADDR_W'(32 * k)});
          expQ.push_back(e);
          @(negedge clk);
          start = 1'b0;
          break;
        end
        @(negedge clk);
        start = 1'b0;
      end
      inValid = 1'b0;
      if (k % 3 == 2) @(negedge clk);
    end
    for (int w = 0; w < 300 && !done; w++) @(negedge clk);
    @(negedge clk); #2;
    chk(done === 1'b1, "R7 done holds", {255'b0, done}, 256'd1);
    chk(expQ.size() == 0, "R6 all beats produced", 256'(expQ.size()), 256'd0);
    chk(beatsSeen - startBeats == count, poke ? "R10 beat count unchanged" : "R6 beat count",
        256'(beatsSeen - startBeats), 256'(count));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(outValid === 1'b0 && inReady === 1'b0, "R1 reset handshake", {254'b0, outValid, inReady}, 256'd0);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset status", {254'b0, busy, done}, 256'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    chk(busy === 1'b0 && done === 1'b0 && outValid === 1'b0, "R1 after reset",
        {253'b0, busy, done, outValid}, 256'd0);

    stallMode = 0;
    runJob(3, 32'h0000_1000, 32'h0000_8000, 0, 1'b0);
    runJob(2, 32'h0000_2000, 32'h0001_0000, 1, 1'b0);
    stallMode = 1;
    runJob(7, 32'h0000_3000, 32'h0002_0000, 0, 1'b0);
    runJob(5, 32'h0000_4000, 32'h0003_0000, 1, 1'b0);
    runJob(0, 32'h0000_5000, 32'h0004_0000, 0, 1'b0);
    stallMode = 0;
    runJob(4, 32'h0000_6000, 32'h0005_0000, 0, 1'b1);
    runJob(1, 32'h0000_7000, 32'h0006_0000, 1, 1'b0);
    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule